// File: doc/BRIEF.md
# Single-Wire RGB Pixel Serializer

This block drives a chain of addressable RGB LED pixels over one data wire. It converts a stream of 32-bit pixel words into a pulse-width-coded waveform. Each bit is a high phase followed by a low phase, and the two phase lengths differ for a one and for a zero. The 24 colour bits of every word are first put into one of six channel orders. They are then sent most significant bit first.

A frame begins with a one-cycle start pulse. At that edge the block captures a pixel count, a packed timing word, a format code and a latch-interval length. It then pulls that many pixels from a ready/valid stream. After the final bit it holds the wire low for the latch interval. Finally it raises a one-cycle completion pulse, in the same cycle that the busy flag drops. All durations are counted in cycles of the module clock.

Top module: `pixel_wire_tx`

## Requirements
- R1: While reset is asserted and right after it is released, `line_out`, `busy`, `pix_ready` and `frame_done` are all low.
- R2: A start pulse taken while idle, with `cfg_frame_len` = N > 0, reads exactly N pixel words through the `pix_valid`/`pix_ready` handshake. It sends 24 bits per word, most significant bit first. Bits [31:24] of each word are ignored.
- R3: The timing word holds four fields. The one-bit high count is in [26:21] and the one-bit low count in [20:16]. The zero-bit high count is in [10:6] and the zero-bit low count in [5:0]. Each bit drives `line_out` high for its high count and then low for its low count, in clock cycles. A count of 0 behaves as 1.
- R4: A pixel word holds channel 0 in [23:16], channel 1 in [15:8] and channel 2 in [7:0]. The transmit order by format code is: 0 sends 0,1,2; 1 sends 0,2,1; 2 sends 1,0,2; 3 sends 1,2,0; 4 sends 2,0,1; 5 sends 2,1,0. Codes 6 and 7 behave as code 0.
- R5: If the next pixel is already valid when the previous pixel's last low phase ends, its first high phase starts in the very next cycle. No extra low cycle is inserted.
- R6: If no pixel is valid when one is needed, `line_out` stays low and the block waits for one. Then it continues with the correct waveform.
- R7: After the low phase of the final bit, `line_out` stays low for `cfg_reset_cycles` cycles, where 0 behaves as 1. Then `frame_done` is high for exactly one cycle, and `busy` is low in that same cycle.
- R8: A start with `cfg_frame_len` = 0 reads no pixels. It keeps `busy` high for the latch interval only, then pulses `frame_done`.
- R9: A start pulse while busy is ignored. Changes to the configuration inputs during a frame have no effect on that frame.
- R10: Whenever `busy` is low, `line_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (sampled while idle) |
| cfg_frame_len | input | 13 | Number of pixels in the frame |
| cfg_timing | input | 27 | Packed high/low cycle counts for both bit values |
| cfg_format | input | 3 | Channel order code |
| cfg_reset_cycles | input | 16 | Latch interval after the last bit, in cycles |
| pix_valid | input | 1 | Pixel word available |
| pix_data | input | 32 | Pixel word, colour in [23:0] |
| pix_ready | output | 1 | Pixel word taken at this edge when valid |
| line_out | output | 1 | Serial data wire to the pixel chain |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle pulse at the end of the frame |

## Verification
The embedded properties assume three things about the inputs: `rst_n` starts asserted, `pix_data` holds steady while `pix_valid` is high and unaccepted, and a pixel word is not withdrawn by the source in a cycle where `pix_ready` is high. The stimulus honours all three. It changes a pixel only at the falling edge after a handshake. It drops `pix_valid` only when no transfer is pending. It pulses `start` at a falling edge, and repeats it mid-frame only where `pix_ready` is certain to be low. Random timing words always give the one-bit and zero-bit high phases different effective lengths. That lets the bench recover every transmitted bit from the measured high width alone.

// File: rtl/pwtx_pkg.sv
package pwtx_pkg;

  localparam int COLOR_W = 24;
  localparam int TIM_W   = 27;
  localparam int PH_W    = 6;

  // field positions inside the packed timing word
  localparam int ONE_HI_LSB  = 21;
  localparam int ONE_LO_LSB  = 16;
  localparam int ZERO_HI_LSB = 6;
  localparam int ZERO_LO_LSB = 0;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_HIGH  = 3'd2,
    ST_LOW   = 3'd3,
    ST_LATCH = 3'd4
  } tx_state_e;

  function automatic logic [PH_W-1:0] high_len(input logic [TIM_W-1:0] t, input logic b);
    if (b) high_len = t[ONE_HI_LSB +: 6];
    else   high_len = {1'b0, t[ZERO_HI_LSB +: 5]};
  endfunction

  function automatic logic [PH_W-1:0] low_len(input logic [TIM_W-1:0] t, input logic b);
    if (b) low_len = {1'b0, t[ONE_LO_LSB +: 5]};
    else   low_len = t[ZERO_LO_LSB +: 6];
  endfunction

endpackage

// File: rtl/pwtx_order.sv
module pwtx_order #(
  parameter int CH_W = 8
) (
  input  logic [2:0]        fmt,
  input  logic [3*CH_W-1:0] color_in,
  output logic [3*CH_W-1:0] color_out
);

  logic [CH_W-1:0] ch [3];

  for (genvar g = 0; g < 3; g++) begin : g_split
    assign ch[g] = color_in[(2-g)*CH_W +: CH_W];
  end

  always_comb begin
    unique case (fmt)
      3'd1:    color_out = {ch[0], ch[2], ch[1]};
      3'd2:    color_out = {ch[1], ch[0], ch[2]};
      3'd3:    color_out = {ch[1], ch[2], ch[0]};
      3'd4:    color_out = {ch[2], ch[0], ch[1]};
      3'd5:    color_out = {ch[2], ch[1], ch[0]};
      default: color_out = {ch[0], ch[1], ch[2]};
    endcase
  end

endmodule

// File: rtl/pwtx_downcnt.sv
module pwtx_downcnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         last
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign last   = (cnt_q <= W'(1));
  assign cnt_en = load | (en & ~last);

  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = load_val;
    else if (cnt_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(load) && !$past(last)) |-> (cnt_q == $past(cnt_q) - 1'b1));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && !$past(en)) |-> $stable(cnt_q));

endmodule

// File: rtl/pixel_wire_tx.sv
module pixel_wire_tx
  import pwtx_pkg::*;
#(
  parameter int LEN_W = 13,
  parameter int RST_W = 16,
  parameter int PIX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] cfg_frame_len,
  input  logic [26:0]      cfg_timing,
  input  logic [2:0]       cfg_format,
  input  logic [RST_W-1:0] cfg_reset_cycles,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             pix_ready,
  output logic             line_out,
  output logic             busy,
  output logic             frame_done
);

  localparam int BIDX_W = $clog2(COLOR_W);
  localparam logic [BIDX_W-1:0] TOP_BIT = BIDX_W'(COLOR_W - 1);
  localparam logic [2:0] FMT_RST = 3'd2;

  tx_state_e          st_q, st_d;
  logic [COLOR_W-1:0] shreg_q, shreg_d;
  logic [BIDX_W-1:0]  bidx_q, bidx_d;
  logic [LEN_W-1:0]   left_q, left_d;
  logic [2:0]         fmt_q;
  logic [TIM_W-1:0]   tim_q;
  logic [RST_W-1:0]   rlen_q;
  logic               done_q, done_d;

  logic               cfg_en, pix_take, ready_c;
  logic [COLOR_W-1:0] ordered;
  logic               ph_load, ph_en, ph_last;
  logic [PH_W-1:0]    ph_val;
  logic               rs_load, rs_en, rs_last;
  logic [RST_W-1:0]   rs_val;
  logic               unused_ok;

  assign unused_ok = ^{pix_data[PIX_W-1:COLOR_W], tim_q[15:11]};

  pwtx_order #(.CH_W(COLOR_W/3)) u_order (
    .fmt       (fmt_q),
    .color_in  (pix_data[COLOR_W-1:0]),
    .color_out (ordered)
  );

  pwtx_downcnt #(.W(PH_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_val),
    .en       (ph_en),
    .last     (ph_last)
  );

  pwtx_downcnt #(.W(RST_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rs_load),
    .load_val (rs_val),
    .en       (rs_en),
    .last     (rs_last)
  );

  assign cfg_en   = (st_q == ST_IDLE) && start;
  assign rs_val   = (st_q == ST_IDLE) ? cfg_reset_cycles : rlen_q;
  assign pix_take = ready_c && pix_valid;

  // next-state process
  always_comb begin
    st_d    = st_q;
    shreg_d = shreg_q;
    bidx_d  = bidx_q;
    left_d  = left_q;
    ph_load = 1'b0;
    ph_val  = '0;
    ph_en   = 1'b0;
    rs_load = 1'b0;
    rs_en   = 1'b0;
    ready_c = 1'b0;
    done_d  = (st_q == ST_LATCH) && rs_last;

    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          left_d = cfg_frame_len;
          if (cfg_frame_len == '0) begin
            rs_load = 1'b1;
            st_d    = ST_LATCH;
          end else begin
            st_d = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        ready_c = 1'b1;
      end
      ST_HIGH: begin
        ph_en = 1'b1;
        if (ph_last) begin
          ph_load = 1'b1;
          ph_val  = low_len(tim_q, shreg_q[COLOR_W-1]);
          st_d    = ST_LOW;
        end
      end
      ST_LOW: begin
        ph_en = 1'b1;
        if (ph_last) begin
          if (bidx_q != '0) begin
            shreg_d = shreg_q << 1;
            bidx_d  = bidx_q - 1'b1;
            ph_load = 1'b1;
            ph_val  = high_len(tim_q, shreg_q[COLOR_W-2]);
            st_d    = ST_HIGH;
          end else if (left_q == '0) begin
            rs_load = 1'b1;
            st_d    = ST_LATCH;
          end else begin
            ready_c = 1'b1;
            st_d    = ST_FETCH;
          end
        end
      end
      ST_LATCH: begin
        rs_en = 1'b1;
        if (rs_last) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase

    if (pix_take) begin
      shreg_d = ordered;
      bidx_d  = TOP_BIT;
      left_d  = left_q - 1'b1;
      ph_load = 1'b1;
      ph_val  = high_len(tim_q, ordered[COLOR_W-1]);
      st_d    = ST_HIGH;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      shreg_q <= '0;
      bidx_q  <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      shreg_q <= shreg_d;
      bidx_q  <= bidx_d;
      left_q  <= left_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q  <= FMT_RST;
      tim_q  <= '0;
      rlen_q <= '0;
    end else if (cfg_en) begin
      fmt_q  <= cfg_format;
      tim_q  <= cfg_timing;
      rlen_q <= cfg_reset_cycles;
    end
  end

  assign pix_ready  = ready_c;
  assign line_out   = (st_q == ST_HIGH);
  assign busy       = (st_q != ST_IDLE);
  assign frame_done = done_q;

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy);

  // R7
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_out);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R5
  accept_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && pix_valid) |=> line_out);

  // R6
  stall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && !pix_valid) |=> (!line_out && busy));

  // R4
  order_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && pix_valid) |-> ($countones(ordered) == $countones(pix_data[COLOR_W-1:0])));

endmodule

// File: tb/pixel_wire_tx_test.sv
module pixel_wire_tx_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] cfg_frame_len = '0;
  logic [26:0] cfg_timing = '0;
  logic [2:0]  cfg_format = '0;
  logic [15:0] cfg_reset_cycles = '0;
  logic        pix_valid = 1'b0;
  logic [31:0] pix_data = '0;
  logic        pix_ready, line_out, busy, frame_done;

  always #5 clk = ~clk;

  pixel_wire_tx uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_frame_len(cfg_frame_len),
    .cfg_timing(cfg_timing), .cfg_format(cfg_format), .cfg_reset_cycles(cfg_reset_cycles),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .line_out(line_out), .busy(busy), .frame_done(frame_done)
  );

  int checks = 0, errors = 0, cyc = 0;
  int mh [0:8191];
  int ml [0:8191];
  int nb = 0, hc = 0, lc = 0, done_cnt = 0, busy_cnt = 0, idle_hi = 0;
  bit inbit = 0, prevl = 0;
  logic [31:0] px [0:63];
  bit          ebit [0:1535];

  // waveform monitor: measures every high and low phase
  always @(negedge clk) begin
    cyc++;
    if (busy) busy_cnt++;
    if (!busy && line_out) idle_hi++;
    if (frame_done) begin
      done_cnt++;
      if (inbit) begin ml[nb-1] = lc; inbit = 0; end
    end else if (line_out && !prevl) begin
      if (inbit) ml[nb-1] = lc;
      inbit = 0;
      hc = 1;
    end else if (line_out) begin
      hc++;
    end else if (prevl) begin
      if (nb < 8191) begin mh[nb] = hc; nb++; end
      inbit = 1;
      lc = 1;
    end else if (inbit) begin
      lc++;
    end
    prevl = line_out;
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [23:0] exp_order(input logic [2:0] f, input logic [23:0] w);
    logic [7:0] c0, c1, c2;
    int a, b, c;
    c0 = w[23:16]; c1 = w[15:8]; c2 = w[7:0];
    case (f)
      3'd1: begin a = 0; b = 2; c = 1; end
      3'd2: begin a = 1; b = 0; c = 2; end
      3'd3: begin a = 1; b = 2; c = 0; end
      3'd4: begin a = 2; b = 0; c = 1; end
      3'd5: begin a = 2; b = 1; c = 0; end
      default: begin a = 0; b = 1; c = 2; end
    endcase
    return {(a == 0) ? c0 : (a == 1) ? c1 : c2,
            (b == 0) ? c0 : (b == 1) ? c1 : c2,
            (c == 0) ? c0 : (c == 1) ? c1 : c2};
  endfunction

  function automatic logic [26:0] rand_tim(input int mx);
    int zh, oh, ol, zl;
    zh = 1 + $urandom % mx;
    oh = zh + 1 + $urandom % mx;
    ol = $urandom % (mx + 1);
    zl = $urandom % (mx + 1);
    return {6'(oh), 5'(ol), 5'd0, 5'(zh), 6'(zl)};
  endfunction

  task automatic run_frame(input int n, input logic [2:0] f, input logic [26:0] t,
                           input int rs, input bit stall, input bit disturb, input string tag);
    int base, d0, b0, ih0, nbad_h, nbad_in, nbad_bd, lastl, hi1, hi0, lo1, lo0;
    hi1 = eff(t[26:21]); lo1 = eff(t[20:16]); hi0 = eff(t[10:6]); lo0 = eff(t[5:0]);
    for (int i = 0; i < n; i++) begin
      logic [23:0] o;
      px[i] = $urandom;
      o = exp_order(f, px[i][23:0]);
      for (int k = 0; k < 24; k++) ebit[i*24+k] = o[23-k];
    end
    base = nb; d0 = done_cnt; b0 = busy_cnt; ih0 = idle_hi;
    cfg_frame_len = 13'(n); cfg_format = f; cfg_timing = t; cfg_reset_cycles = 16'(rs);
    pix_valid = (n > 0) && !stall;
    pix_data  = px[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (stall) begin
        pix_valid = 1'b0;
        repeat (250) @(negedge clk);
      end
      pix_valid = 1'b1;
      pix_data  = px[i];
      while (!pix_ready) @(negedge clk);
      @(negedge clk);
      pix_valid = 1'b0;
      if (i + 1 < n) begin
        pix_data  = px[i+1];
        pix_valid = !stall;
      end
      if (disturb && i == 0) begin
        cfg_format = ~f; cfg_timing = ~t; cfg_reset_cycles = 16'(rs + 50);
        cfg_frame_len = 13'(n + 3);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    pix_valid = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done_cnt - d0 == 1, {tag, " R7 done pulses"}, done_cnt - d0, 1);
    chk(!busy && !line_out, {tag, " R7 idle after done"}, busy, 0);
    chk(idle_hi == ih0, "R10 idle line high", idle_hi - ih0, 0);
    if (n == 0) begin
      chk(busy_cnt - b0 == eff(rs), "R8 latch-only busy cycles", busy_cnt - b0, eff(rs));
      chk(nb == base, "R8 no bits sent", nb - base, 0);
    end else begin
      chk(nb - base == n * 24, {tag, " R2 bit count"}, nb - base, n * 24);
      nbad_h = 0; nbad_in = 0; nbad_bd = 0;
      for (int j = 0; j < n * 24 && base + j < nb; j++) begin
        int eh, el;
        eh = ebit[j] ? hi1 : hi0;
        el = ebit[j] ? lo1 : lo0;
        if (mh[base+j] != eh) nbad_h++;
        if (j != n * 24 - 1) begin
          if (j % 24 == 23) begin
            if (stall ? (ml[base+j] <= el) : (ml[base+j] != el)) nbad_bd++;
          end else if (ml[base+j] != el) nbad_in++;
        end
      end
      chk(nbad_h == 0, {tag, " R4 R3 bit values and high widths"}, nbad_h, 0);
      chk(nbad_in == 0, {tag, " R3 low widths"}, nbad_in, 0);
      if (n > 1)
        chk(nbad_bd == 0, stall ? "R6 stalled boundary lows" : {tag, " R5 pixel boundary lows"}, nbad_bd, 0);
      lastl = ebit[n*24-1] ? lo1 : lo0;
      if (nb - base == n * 24)
        chk(ml[nb-1] == lastl + eff(rs), {tag, " R7 final low plus latch"}, ml[nb-1], lastl + eff(rs));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!line_out && !busy && !pix_ready && !frame_done, "R1 outputs in reset",
        {line_out, busy, pix_ready, frame_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!line_out && !busy && !pix_ready && !frame_done, "R1 outputs after release",
        {line_out, busy, pix_ready, frame_done}, 0);

    // directed: default-like timing, GRB order
    run_frame(2, 3'd2, {6'd5, 5'd3, 5'd0, 5'd2, 6'd6}, 10, 0, 0, "R2");
    // every format code, including 6 and 7
    for (int f = 0; f < 8; f++) run_frame(2, 3'(f), rand_tim(4), 3 + f, 0, 0, "R4");
    // zero counts act as one, zero latch acts as one
    run_frame(2, 3'd0, {6'd3, 5'd0, 5'd0, 5'd0, 6'd0}, 0, 0, 0, "R3");
    // widest counts
    run_frame(1, 3'd5, {6'd63, 5'd31, 5'd0, 5'd31, 6'd63}, 20, 0, 0, "R3");
    // empty frame
    run_frame(0, 3'd1, rand_tim(3), 7, 0, 0, "R8");
    // source stalls between pixels
    run_frame(3, 3'd3, rand_tim(3), 5, 1, 0, "R6");
    // restart and configuration changes during a frame
    run_frame(3, 3'd4, rand_tim(3), 6, 0, 1, "R9");
    // constrained random frames
    for (int r = 0; r < 6; r++)
      run_frame(1 + $urandom % 6, 3'($urandom % 8), rand_tim(5), $urandom % 30, 0, 0, "R2");
    summary();
  end

endmodule